// File: doc/BRIEF.md
# Burst-Fill Rate-Paced Sample FIFO

This block sits between a processing engine that produces audio samples in fast groups and an output converter that needs exactly one sample per sample period. The engine hands over a group of 16 samples back to back through a valid/ready write port. The group arrives once per block period, which is 16 sample periods long. The block stores the samples and releases them one at a time on a sample strobe. It makes that strobe itself by dividing the system clock by `CLK_HZ / RATE_HZ`, so the interval between released samples is the same every time.

Storage is a power-of-two ring with one extra wrap bit on each pointer, so a full ring and an empty ring can be told apart. Two sticky flags report trouble. One is set when the strobe finds nothing to release. The other is set when the writer offers a sample while there is no room for it.

Top module: `burst_pace_fifo`

## Requirements
- R1: After reset, `out_sample` is 0, `starved` and `dropped` are 0, and `in_ready` is 1.
- R2: `out_tick` is a one-cycle pulse that recurs every DIV = CLK_HZ/RATE_HZ clock cycles, whatever data is flowing. The first pulse appears DIV cycles after reset is released.
- R3: On each strobe that finds stored data, `out_sample` takes the oldest stored sample. Samples leave in the order they were accepted, one per strobe.
- R4: The write port accepts a group of 16 samples on 16 consecutive cycles with `in_ready` held high. It holds up to DEPTH (default 32) samples.
- R5: `out_sample` changes only in the cycle that `out_tick` marks. It holds its value between strobes.
- R6: A strobe that finds the storage empty leaves `out_sample` at its last value and sets the sticky `starved` flag.
- R7: An accepted write clears `starved`.
- R8: `in_ready` is 0 while DEPTH samples are stored.
- R9: A write offered while `in_ready` is 0 sets the sticky `dropped` flag. The offered sample is discarded and never appears on `out_sample`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Writer offers a sample |
| in_ready | output | 1 | Storage has room; a sample is accepted when this and `in_valid` are both 1 |
| in_data | input | DW | Offered sample |
| out_sample | output | DW | Paced output sample register |
| out_tick | output | 1 | One-cycle pulse in the cycle a new `out_sample` value becomes visible |
| starved | output | 1 | Sticky: a strobe found the storage empty |
| dropped | output | 1 | Sticky: a write was offered while the storage was full |

## Verification
The case hardest to reach from the ports is a completely full ring. The strobe keeps draining the ring while the writer fills it, so a fill that starts at a random moment may never reach full. The bench therefore builds the block with a 64-cycle strobe period. It waits for an `out_tick` pulse and then writes 32 samples plus one extra offer, all before the next strobe can remove anything. It then drains 33 strobes. This shows that the extra sample was discarded, and that the 33rd strobe starves and repeats the last value.

// File: rtl/pace_pkg.sv
package pace_pkg;

   // What the output stage does when a strobe arrives
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_POP    = 2'd1,
      ACT_STARVE = 2'd2
   } rd_act_e;

endpackage

// File: rtl/pace_strobe_gen.sv
module pace_strobe_gen #(
   parameter int CLK_HZ  = 125_000_000,
   parameter int RATE_HZ = 48_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int DIV  = CLK_HZ / RATE_HZ;
   localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_wrap
         // The count wraps by itself, so no compare-and-clear is needed
         always_ff @(posedge clk) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
         assign tick = &cnt;
      end else begin : g_modulo
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate

   // R2
   tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/pace_store.sv
module pace_store #(
   parameter int DW    = 24,
   parameter int DEPTH = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          full,
   output logic          empty
);
   localparam int AW = $clog2(DEPTH);

   logic [AW:0]   wr_ptr, rd_ptr;
   logic [AW:0]   level;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
   end

   assign rd_data = mem[rd_ptr[AW-1:0]];
   assign empty   = (wr_ptr == rd_ptr);
   assign full    = (wr_ptr[AW] != rd_ptr[AW]) &&
                    (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign level   = wr_ptr - rd_ptr;

   // R3
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);

   // R8
   push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);

   // R4
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= (AW+1)'(DEPTH));

endmodule

// File: rtl/pace_out_stage.sv
module pace_out_stage #(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          empty,
   input  logic          wr_acc,
   input  logic [DW-1:0] fifo_data,
   output logic          pop,
   output logic [DW-1:0] sample,
   output logic          out_tick,
   output logic          starved
);
   import pace_pkg::*;

   rd_act_e act;

   always_comb begin
      if (!tick)      act = ACT_HOLD;
      else if (empty) act = ACT_STARVE;
      else            act = ACT_POP;
   end

   assign pop = (act == ACT_POP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample   <= '0;
         out_tick <= 1'b0;
         starved  <= 1'b0;
      end else begin
         out_tick <= tick;
         unique case (act)
            ACT_POP:    sample <= fifo_data;
            ACT_STARVE: starved <= 1'b1;
            default:    ;
         endcase
         // A starving strobe takes priority over a clearing write
         if (wr_acc && act != ACT_STARVE) starved <= 1'b0;
      end
   end

   // R5
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(sample));

   // R6
   starve_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && empty) |=> (starved && $stable(sample)));

   // R7
   write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && !tick) |=> !starved);

endmodule

// File: rtl/burst_pace_fifo.sv
module burst_pace_fifo #(
   parameter int DW      = 24,
   parameter int DEPTH   = 32,
   parameter int CLK_HZ  = 125_000_000,
   parameter int RATE_HZ = 48_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   output logic [DW-1:0] out_sample,
   output logic          out_tick,
   output logic          starved,
   output logic          dropped
);
   localparam int BURST = 16;
   localparam int DIV   = CLK_HZ / RATE_HZ;

   generate
      if (DEPTH < BURST || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 16");
      end
      if (DIV < 2) begin : g_bad_div
         $error("CLK_HZ must be at least twice RATE_HZ");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic          tick, full, empty, pop, wr_acc;
   logic [DW-1:0] head;

   assign in_ready = !full;
   assign wr_acc   = in_valid && !full;

   pace_strobe_gen #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) u_strobe (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   pace_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_acc), .wr_data(in_data),
      .rd_en(pop), .rd_data(head),
      .full(full), .empty(empty)
   );

   pace_out_stage #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .tick(tick), .empty(empty),
      .wr_acc(wr_acc), .fifo_data(head), .pop(pop),
      .sample(out_sample), .out_tick(out_tick), .starved(starved)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                dropped <= 1'b0;
      else if (in_valid && full) dropped <= 1'b1;
   end

   // R9
   drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> dropped);

   // R9
   drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dropped |=> dropped);

endmodule

// File: tb/tb_burst_pace_fifo.sv
`timescale 1ns/1ps
module tb_burst_pace_fifo;
   localparam int DW    = 16;
   localparam int DEPTH = 32;
   localparam int DIV   = 64;

   localparam logic [DW-1:0] VEC [16] = '{
      16'h1111, 16'h2222, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF,
      16'h0A0A, 16'hA5A5, 16'h5A5A, 16'h1234, 16'hFEDC, 16'h0F0F,
      16'hF0F0, 16'h00FF, 16'hFF00, 16'hBEEF };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready, out_tick, starved, dropped;
   logic [DW-1:0] out_sample;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   burst_pace_fifo #(.DW(DW), .DEPTH(DEPTH), .CLK_HZ(DIV * 48000),
                     .RATE_HZ(48000)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_sample(out_sample), .out_tick(out_tick),
      .starved(starved), .dropped(dropped)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_tick();
      @(negedge clk);
      while (!out_tick) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int t0, t1;
      int ready_bad;
      logic [DW-1:0] held;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t0 = cyc;
      // R1 reset state
      check(out_sample == 0, "R1 out_sample", 32'(out_sample), 0);
      check(!starved && !dropped, "R1 flags", {starved, dropped}, 0);
      check(in_ready, "R1 in_ready", 32'(in_ready), 1);

      // R2 first strobe and period; R6 strobe on empty storage
      wait_tick();
      check(cyc - t0 == DIV, "R2 first strobe", cyc - t0, DIV);
      check(starved, "R6 starve on empty", 32'(starved), 1);
      check(out_sample == 0, "R6 repeat value", 32'(out_sample), 0);
      t1 = cyc;
      @(negedge clk);
      check(!out_tick, "R2 pulse width", 32'(out_tick), 0);
      wait_tick();
      check(cyc - t1 == DIV, "R2 interval", cyc - t1, DIV);

      // R4 back-to-back burst of 16 from the table
      ready_bad = 0;
      for (int i = 0; i < 16; i++) begin
         in_valid = 1'b1;
         in_data  = VEC[i];
         if (!in_ready) ready_bad++;
         @(negedge clk);
      end
      in_valid = 1'b0;
      check(ready_bad == 0, "R4 burst ready", ready_bad, 0);
      check(!starved, "R7 write clears starved", 32'(starved), 0);

      // R3 table walk: one sample per strobe in order; R5 hold mid-period
      for (int i = 0; i < 16; i++) begin
         wait_tick();
         t1 = cyc;
         check(out_sample == VEC[i], "R3 order", 32'(out_sample), 32'(VEC[i]));
         if (i == 3 || i == 9) begin
            held = out_sample;
            repeat (DIV / 2) @(negedge clk);
            check(out_sample == held, "R5 hold", 32'(out_sample), 32'(held));
         end
      end
      check(cyc - t1 == 0, "R2 sync", cyc - t1, 0);

      // R6 drained: repeat last, starved set
      wait_tick();
      check(out_sample == VEC[15], "R6 repeat last", 32'(out_sample), 32'(VEC[15]));
      check(starved, "R6 starved set", 32'(starved), 1);

      // R8 / R9 fill to DEPTH within one strobe period, then offer one more
      wait_tick();
      ready_bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
         in_valid = 1'b1;
         in_data  = DW'(16'h0100 + i * 3);
         if (!in_ready) ready_bad++;
         @(negedge clk);
      end
      check(ready_bad == 0, "R4 depth accept", ready_bad, 0);
      in_data = 16'hDEAD;
      check(!in_ready, "R8 ready low when full", 32'(in_ready), 0);
      check(!dropped, "R9 not yet dropped", 32'(dropped), 0);
      @(negedge clk);
      in_valid = 1'b0;
      check(dropped, "R9 dropped set", 32'(dropped), 1);

      for (int i = 0; i < DEPTH; i++) begin
         wait_tick();
         check(out_sample == DW'(16'h0100 + i * 3), "R3 full drain order",
               32'(out_sample), 32'(16'h0100 + i * 3));
      end
      wait_tick();
      check(out_sample == DW'(16'h0100 + (DEPTH - 1) * 3), "R9 extra discarded",
            32'(out_sample), 32'(16'h0100 + (DEPTH - 1) * 3));
      check(starved, "R6 starved after full drain", 32'(starved), 1);
      check(dropped, "R9 dropped sticky", 32'(dropped), 1);
      check(in_ready, "R8 ready after drain", 32'(in_ready), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule